// File: doc/BRIEF.md
# Test-and-Test-and-Set Spin Lock Engine

This block is a per-core controller that takes and gives back a binary spin lock kept in shared memory. A lock word of 0 means the lock is free and 1 means some core owns it. When told to acquire, the engine reads the lock word with ordinary loads, which cost no bus lock. It keeps reading for as long as it sees the lock taken. Only when a read shows the lock free does it issue one atomic test-and-set. If that atomic attempt loses a race to another core, the engine goes back to plain reads and does not retry the atomic operation at once. Giving the lock back is a single ordinary store of 0.

The engine drives a memory request port with a valid/ready handshake and at most one request in flight. The port carries an operation code, an address and write data. Responses come back as a one-cycle valid pulse with read data and, for a test-and-set, a zero flag that is set when the word was 0 and has now been set to 1. The engine reports ownership on `held_o`. It also counts the test-and-set requests issued since the last acquire, so a system can confirm that atomic traffic stays low under contention. The lock word in memory must start at 0.

Top module: `ttas_lock_engine`

## Requirements
- R1: After reset `held_o` is 0, `req_valid_o` is 0 and `tas_count_o` is 0.
- R2: While the most recent load response returned the value 1, every request the engine issues is a load (op code 2'b00) and never a test-and-set.
- R3: After a load response returns any value other than 1, the next request is exactly one test-and-set (op code 2'b10) to the lock address.
- R4: A test-and-set response with `rsp_zero_i` = 1 makes `held_o` rise in the following cycle. With `rsp_zero_i` = 0 the engine goes back to issuing loads and `held_o` stays 0.
- R5: A release while the lock is held issues one store (op code 2'b01) with write data 0 to the lock address. `held_o` stays 1 until the store response and drops in the cycle after it.
- R6: An acquire pulse is taken only while the engine is idle, and a release pulse only while the lock is held. Pulses at any other time issue no request and leave `held_o` unchanged.
- R7: `tas_count_o` counts the test-and-set requests accepted by the port since the last accepted acquire. An accepted acquire clears it to 0, and it saturates at 2^CNT_W-1.
- R8: A request keeps its valid, op code and address steady until `req_ready_i` accepts it. No new request is issued while one is waiting for its response.
- R9: The lock address is captured from `lock_addr_i` when an acquire is accepted. All requests of that acquire and the release that follows use this captured address, whatever `lock_addr_i` does later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acquire_i | input | 1 | Acquire command pulse |
| release_i | input | 1 | Release command pulse |
| lock_addr_i | input | AW | Lock word address, captured on acquire |
| held_o | output | 1 | Lock is owned by this core |
| tas_count_o | output | CNT_W | Test-and-set requests issued since the last acquire, saturating |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory port accepts the request |
| req_op_o | output | 2 | 00 load, 01 store, 10 test-and-set |
| req_addr_o | output | AW | Request address |
| req_wdata_o | output | DW | Store data (always 0) |
| rsp_valid_i | input | 1 | Response pulse |
| rsp_data_i | input | DW | Load read data |
| rsp_zero_i | input | 1 | Test-and-set found 0 and set the word |

## Verification
The bench models memory together with a second core. That core can hold the lock for a set number of polls, and it can grab the lock in the gap between a free-looking load and the engine's test-and-set. It sweeps the initial busy time, the number of lost races, the hold time after each race, the response latency and the ready stall. A design that retried the atomic operation after a failure, or that issued it while the lock looked busy, would show too many test-and-set requests or a wrong load count. A design that dropped ownership early or raised it late would trip the cycle-by-cycle `held_o` comparison. A run with more lost races than the counter can hold checks the saturation. Stray acquire and release pulses, and a changing `lock_addr_i`, probe whether commands are ignored outside their state and whether the address is captured.

// File: rtl/ttas_pkg.sv
package ttas_pkg;
  typedef enum logic [1:0] {
    MEM_LOAD  = 2'b00,
    MEM_STORE = 2'b01,
    MEM_TAS   = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_REQ,
    ST_POLL_WAIT,
    ST_TAS_REQ,
    ST_TAS_WAIT,
    ST_HELD,
    ST_REL_REQ,
    ST_REL_WAIT
  } lock_state_e;
endpackage

// File: rtl/ttas_attempt_ctr.sv
module ttas_attempt_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ttas_ctl.sv
module ttas_ctl
  import ttas_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acquire_i,
  input  logic          release_i,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_zero_i,
  output logic          req_valid_o,
  output mem_op_e       req_op_o,
  output logic          held_o,
  output logic          acq_take_o,
  output logic          tas_fire_o
);
  localparam logic [DW-1:0] LockBusy = DW'(1);

  lock_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    req_valid_o = 1'b0;
    req_op_o    = MEM_LOAD;
    acq_take_o  = 1'b0;
    tas_fire_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (acquire_i) begin
        acq_take_o = 1'b1;
        state_d    = ST_POLL_REQ;
      end
      ST_POLL_REQ: begin
        req_valid_o = 1'b1;
        if (req_ready_i) state_d = ST_POLL_WAIT;
      end
      ST_POLL_WAIT: if (rsp_valid_i) begin
        // anything other than busy is worth one atomic attempt
        state_d = (rsp_data_i == LockBusy) ? ST_POLL_REQ : ST_TAS_REQ;
      end
      ST_TAS_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = MEM_TAS;
        if (req_ready_i) begin
          tas_fire_o = 1'b1;
          state_d    = ST_TAS_WAIT;
        end
      end
      ST_TAS_WAIT: if (rsp_valid_i) begin
        // lost race falls back to cheap polling
        state_d = rsp_zero_i ? ST_HELD : ST_POLL_REQ;
      end
      ST_HELD: if (release_i) state_d = ST_REL_REQ;
      ST_REL_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = MEM_STORE;
        if (req_ready_i) state_d = ST_REL_WAIT;
      end
      ST_REL_WAIT: if (rsp_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign held_o = (state_q == ST_HELD) || (state_q == ST_REL_REQ) ||
                  (state_q == ST_REL_WAIT);
endmodule

// File: rtl/ttas_lock_engine.sv
module ttas_lock_engine
  import ttas_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acquire_i,
  input  logic             release_i,
  input  logic [AW-1:0]    lock_addr_i,
  output logic             held_o,
  output logic [CNT_W-1:0] tas_count_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [1:0]       req_op_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [DW-1:0]    req_wdata_o,
  input  logic             rsp_valid_i,
  input  logic [DW-1:0]    rsp_data_i,
  input  logic             rsp_zero_i
);
  logic          acq_take, tas_fire;
  mem_op_e       op;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (acq_take) addr_q <= lock_addr_i;
  end

  ttas_ctl #(.DW(DW)) i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acquire_i  (acquire_i),
    .release_i  (release_i),
    .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_data_i (rsp_data_i),
    .rsp_zero_i (rsp_zero_i),
    .req_valid_o(req_valid_o),
    .req_op_o   (op),
    .held_o     (held_o),
    .acq_take_o (acq_take),
    .tas_fire_o (tas_fire)
  );

  ttas_attempt_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (acq_take),
    .inc_i (tas_fire),
    .cnt_o (tas_count_o)
  );

  assign req_op_o    = op;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = '0;
endmodule

// File: rtl/ttas_lock_chk.sv
module ttas_lock_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             held_o,
  input logic [CNT_W-1:0] tas_count_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [1:0]       req_op_o,
  input logic [AW-1:0]    req_addr_o,
  input logic [DW-1:0]    req_wdata_o,
  input logic             rsp_valid_i,
  input logic [DW-1:0]    rsp_data_i,
  input logic             rsp_zero_i
);
  logic       outst_q, free_seen_q;
  logic [1:0] last_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_q     <= 1'b0;
      free_seen_q <= 1'b0;
      last_op_q   <= 2'b00;
    end else begin
      if (req_valid_o && req_ready_i) begin
        outst_q   <= 1'b1;
        last_op_q <= req_op_o;
        if (req_op_o == 2'b10) free_seen_q <= 1'b0;
      end else if (rsp_valid_i) begin
        outst_q <= 1'b0;
        if (outst_q && last_op_q == 2'b00) free_seen_q <= (rsp_data_i != DW'(1));
      end
    end
  end

  // R8
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_op_o) && $stable(req_addr_o));

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !req_valid_o);

  // R2
  tas_only_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == 2'b10 |-> free_seen_q);

  // R4
  tas_win_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && outst_q && last_op_q == 2'b10 && rsp_zero_i |=> held_o);

  // R4
  tas_lose_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i && outst_q && last_op_q == 2'b10 && !rsp_zero_i |=> !held_o);

  // R5
  held_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> $past(rsp_valid_i && outst_q && last_op_q == 2'b01));

  // R5
  release_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_op_o == 2'b01 |-> req_wdata_o == '0 && held_o);

  // R7
  ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tas_count_o != $past(tas_count_o) |->
      tas_count_o == CNT_W'($past(tas_count_o) + 1'b1) || tas_count_o == '0);
endmodule

bind ttas_lock_engine ttas_lock_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .held_o     (held_o),
  .tas_count_o(tas_count_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_op_o   (req_op_o),
  .req_addr_o (req_addr_o),
  .req_wdata_o(req_wdata_o),
  .rsp_valid_i(rsp_valid_i),
  .rsp_data_i (rsp_data_i),
  .rsp_zero_i (rsp_zero_i)
);

// File: tb/test_ttas_lock_engine.sv
`timescale 1ns/1ps
module test_ttas_lock_engine;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CNT_W = 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acquire = 1'b0, release_c = 1'b0;
  logic [AW-1:0] lock_addr = '0;
  logic held;
  logic [CNT_W-1:0] tas_cnt;
  logic req_valid, req_ready = 1'b0;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic rsp_zero = 1'b0;

  always #2.5 clk = ~clk;

  ttas_lock_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_ttas_lock_engine (
    .clk_i(clk), .rst_ni(rst_n), .acquire_i(acquire), .release_i(release_c),
    .lock_addr_i(lock_addr), .held_o(held), .tas_count_o(tas_cnt),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid),
    .rsp_data_i(rsp_data), .rsp_zero_i(rsp_zero)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory and contender model
  int cfg_lat = 0, cfg_stall = 0, hold = 1;
  int busy_left = 0, race_left = 0;
  bit lock_word = 1'b0, owns = 1'b0;
  int n_load = 0, n_tas = 0, n_store = 0, n_acc = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [1:0] last_op = 2'b00;
  logic [DW-1:0] r_data = '0;
  bit r_zero = 1'b0, armed = 1'b0, exp_held = 1'b0;
  int acc_seq = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst_n && rsp_valid) begin
      if (last_op == 2'b00) armed = (rsp_data != DW'(1));
      if (last_op == 2'b10 && rsp_zero) exp_held = 1'b1;
      if (last_op == 2'b01) exp_held = 1'b0;
    end
    if (rst_n && req_valid && req_ready) begin
      n_acc++;
      last_op = req_op;
      chk(req_addr == cur_addr, "R9 addr", int'(req_addr), int'(cur_addr));
      // R2/R3: a free-looking load must be followed by a TAS, a busy one never
      chk((req_op == 2'b10) == armed, "R2/R3 op order", int'(req_op), armed ? 2 : 0);
      armed = 1'b0;
      case (req_op)
        2'b00: begin
          n_load++;
          r_data = DW'(lock_word);
          if (lock_word && owns) begin
            busy_left--;
            if (busy_left == 0) begin lock_word = 1'b0; owns = 1'b0; end
          end else if (!lock_word && race_left > 0) begin
            lock_word = 1'b1; owns = 1'b1; busy_left = hold; race_left--;
          end
        end
        2'b10: begin
          n_tas++;
          r_zero = !lock_word;
          lock_word = 1'b1;
        end
        default: begin
          n_store++;
          chk(req_wdata == '0, "R5 store data", int'(req_wdata), 0);
          lock_word = req_wdata[0];
        end
      endcase
      acc_seq++;
    end
  end

  int served = 0, stall_cnt = 0, wait_cnt = 0;
  bit in_wait = 1'b0;
  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (acc_seq != served) begin
      if (!in_wait) begin in_wait = 1'b1; wait_cnt = cfg_lat; end
      if (wait_cnt == 0) begin
        rsp_valid = 1'b1; rsp_data = r_data; rsp_zero = r_zero;
        served = acc_seq; in_wait = 1'b0;
      end else wait_cnt--;
    end
    if (!req_valid) begin req_ready = 1'b0; stall_cnt = 0; end
    else if (stall_cnt >= cfg_stall) req_ready = 1'b1;
    else begin req_ready = 1'b0; stall_cnt++; end
    #0.5;
    if (rst_n) chk(held == exp_held, "R4/R5 held timing", int'(held), int'(exp_held));
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic wait_held(input bit v, input string req);
    int t = 0;
    while (held != v && t < 400) begin @(negedge clk); t++; end
    chk(held == v, req, int'(held), int'(v));
  endtask

  task automatic run(input int b, input int r, input int h, input int lat,
                     input int stall, input logic [AW-1:0] addr);
    int e_tas, e_load, a0;
    cfg_lat = lat; cfg_stall = stall; hold = h;
    busy_left = b; race_left = r; owns = (b > 0); lock_word = (b > 0);
    n_load = 0; n_tas = 0; n_store = 0;
    cur_addr = addr;
    @(negedge clk);
    lock_addr = addr; acquire = 1'b1;
    @(negedge clk);
    acquire = 1'b0; lock_addr = ~addr;
    wait_held(1'b1, "R4 acquire completes");
    e_tas = r + 1;
    e_load = b + r * (1 + h) + 1;
    chk(n_tas == e_tas, "R3 one TAS per free load", n_tas, e_tas);
    chk(n_load == e_load, "R2 polling loads", n_load, e_load);
    chk(int'(tas_cnt) == ((e_tas > CNT_MAX) ? CNT_MAX : e_tas), "R7 tas count",
        int'(tas_cnt), (e_tas > CNT_MAX) ? CNT_MAX : e_tas);
    // R6: acquire while held is ignored
    a0 = n_acc;
    acquire = 1'b1; @(negedge clk); acquire = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_acc == a0 && held, "R6 acquire ignored when held", n_acc - a0, 0);
    chk(int'(tas_cnt) == ((e_tas > CNT_MAX) ? CNT_MAX : e_tas), "R7 count kept",
        int'(tas_cnt), (e_tas > CNT_MAX) ? CNT_MAX : e_tas);
    release_c = 1'b1; @(negedge clk); release_c = 1'b0;
    wait_held(1'b0, "R5 release completes");
    chk(n_store == 1, "R5 single store", n_store, 1);
    chk(lock_word == 1'b0, "R5 lock freed", int'(lock_word), 0);
  endtask

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    chk(held == 1'b0, "R1 held", int'(held), 0);
    chk(req_valid == 1'b0, "R1 valid", int'(req_valid), 0);
    chk(tas_cnt == '0, "R1 count", int'(tas_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: release while idle is ignored
    a0 = n_acc;
    release_c = 1'b1; @(negedge clk); release_c = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_acc == a0 && !req_valid && !held, "R6 release ignored when idle", n_acc - a0, 0);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 3; r++)
        for (int h = 1; h < 3; h++)
          for (int lat = 0; lat < 3; lat++)
            for (int st = 0; st < 2; st++)
              run(b, r, h, lat, st, AW'(b * 37 + r * 11 + h * 5 + lat * 3 + st + 1));
    // R7 saturation: five attempts into a two-bit counter
    run(1, 4, 1, 1, 1, 8'hA5);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule